// File: doc/BRIEF.md
# Slow-Tick Sleep Counter

This block keeps a 32-bit count that advances while the chip sleeps. It counts slow ticks from one of two sources: a calibrated tick near 1 kHz, or a tick near 32 kHz. Both sources arrive as single-cycle strobes in the system clock domain. The selected tick passes through a prescaler that divides it by a power of two. The count runs up or down and wraps at both ends. While the CPU is halted for debug, the count can be frozen.

Software drives the block through a small strobe interface with three addresses. Address 0 holds the configuration. Address 1 returns the low half of the count. Address 2 returns the high half as it stood at the most recent low read, so the two reads always form one coherent value. A new run bit does not reach the counting path at once. It passes through two stages that are clocked by the selected tick, so starting and stopping lag the write by a couple of slow periods. While the run bit is set, the direction, source and divider fields are locked.

Top module: `slow_tick_timer`

## Requirements
- R1: After reset, the configuration at address 0 reads 0x00000004 (only the freeze bit 2 is set) and the count is zero.
- R2: With the direction bit (bit 1) at 0, each completed prescaled period adds one to the count.
- R3: With the direction bit at 1, each completed prescaled period subtracts one. The count wraps modulo 2^32 in both directions (0 minus 1 gives 0xFFFFFFFF, and 0xFFFFFFFF plus 1 gives 0).
- R4: The divider field (bits 7:4) holds N from 0 to 15. One count step occurs per 2^N selected ticks. The prescaler is cleared while the timer is inactive, so each run starts with a whole period.
- R5: The source bit (bit 3) picks the slow tick input at 0 and the fast tick input at 1. Ticks on the other input have no effect.
- R6: After the run bit (bit 0) is written to 1, the first two selected ticks do not count and the third one does (N=0). After the run bit is written to 0, the first two selected ticks still count and later ticks do not.
- R7: While the stored run bit is 1, writes leave the direction, source and divider fields unchanged. The run bit and the freeze bit stay writable at all times.
- R8: With the freeze bit (bit 2) at 1 and dbg_halt high, neither the count nor the prescaler advances. With the freeze bit at 0, dbg_halt is ignored.
- R9: While rd_en is high, rdata returns the configuration in bits 7:0 at address 0 and count bits 15:0 at address 1, in the same cycle. At address 2, rdata returns count bits 31:16 as latched at the last read of address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Single-cycle strobe of the ~1 kHz calibrated source |
| tick_fast | input | 1 | Single-cycle strobe of the ~32 kHz source |
| dbg_halt | input | 1 | High while the CPU is halted for debug |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is zero when low |
| addr | input | 2 | Register address: 0 configuration, 1 count low, 2 count high |
| wdata | input | 8 | Write data; only the configuration is writable |
| rdata | output | 32 | Read data, combinational from addr while rd_en is high |

## Verification
On every cycle, the assertions check the following: each count step moves the count by exactly one in the configured direction; the count is stable without a step; steps fall only on a selected tick while the timer is active and never during a frozen halt; the locked fields hold while running; and the high shadow is captured only by a low read. Some behaviour shows only across a scenario, so the bench covers it: the two-tick start and stop latency, the 2^N division with trailing ticks counted after a stop, wrap-around in both directions, and a coherent split read across a wrap. The bench covers these with directed sequences and with seeded random runs, comparing against counts worked out from the tick totals.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int DIV_W  = 4;
    localparam int PRE_W  = (2 ** DIV_W) - 1;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LO  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_HI  = 2'd2;

    // Packed MSB first: div[7:4], src_fast[3], halt_freeze[2], down[1], run[0]
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             src_fast;
        logic             halt_freeze;
        logic             down;
        logic             run;
    } st_cfg_t;

    localparam int CFG_W = $bits(st_cfg_t);

    localparam st_cfg_t CFG_RESET = '{div: '0, src_fast: 1'b0, halt_freeze: 1'b1,
                                      down: 1'b0, run: 1'b0};
endpackage

// File: rtl/st_cfg_reg.sv
module st_cfg_reg
    import st_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output st_cfg_t           cfg_q
);
    typedef struct packed {
        st_cfg_t cfg;
    } state_t;

    state_t  st_d, st_q;
    st_cfg_t wr_cfg;

    always_comb begin
        st_d   = st_q;
        wr_cfg = st_cfg_t'(wdata);
        if (wr_en && addr == ADDR_CFG) begin
            st_d.cfg.run         = wr_cfg.run;
            st_d.cfg.halt_freeze = wr_cfg.halt_freeze;
            // mode fields accepted only while the stored run bit is clear
            if (!st_q.cfg.run) begin
                st_d.cfg.down     = wr_cfg.down;
                st_d.cfg.src_fast = wr_cfg.src_fast;
                st_d.cfg.div      = wr_cfg.div;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET};
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;
endmodule

// File: rtl/st_tick_gen.sv
module st_tick_gen
    import st_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_slow,
    input  logic             tick_fast,
    input  logic             dbg_halt,
    input  logic             run,
    input  logic             halt_freeze,
    input  logic             src_fast,
    input  logic [DIV_W-1:0] div,
    output logic             active,
    output logic             step
);
    typedef struct packed {
        logic             sync1;
        logic             active;
        logic [PRE_W-1:0] pre;
    } state_t;

    state_t           st_d, st_q;
    logic             sel_tick;
    logic             frozen;
    logic [PRE_W-1:0] pre_limit;

    always_comb begin
        st_d      = st_q;
        step      = 1'b0;
        sel_tick  = src_fast ? tick_fast : tick_slow;
        frozen    = halt_freeze && dbg_halt;
        pre_limit = ~({PRE_W{1'b1}} << div);

        // run bit crosses two stages clocked by the selected tick
        if (sel_tick) begin
            st_d.sync1  = run;
            st_d.active = st_q.sync1;
        end

        if (!st_q.active) begin
            st_d.pre = '0;
        end else if (sel_tick && !frozen) begin
            if (st_q.pre == pre_limit) begin
                st_d.pre = '0;
                step     = 1'b1;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
endmodule

// File: rtl/st_counter.sv
module st_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             down,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.cnt = down ? st_q.cnt - CNT_W'(1) : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/st_readback.sv
module st_readback
    import st_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  st_cfg_t           cfg,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output logic [HALF_W-1:0] shadow
);
    typedef struct packed {
        logic [HALF_W-1:0] shadow;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_CFG: rdata[CFG_W-1:0]  = cfg;
                ADDR_LO:  rdata[HALF_W-1:0] = cnt[HALF_W-1:0];
                ADDR_HI:  rdata[HALF_W-1:0] = st_q.shadow;
                default:  rdata = '0;
            endcase
            if (addr == ADDR_LO) st_d.shadow = cnt[CNT_W-1:HALF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow = st_q.shadow;
endmodule

// File: rtl/slow_tick_timer.sv
module slow_tick_timer
    import st_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              dbg_halt,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [DATA_W-1:0] rdata
);
    st_cfg_t           cfg_q;
    logic              active;
    logic              step;
    logic [CNT_W-1:0]  cnt;
    logic [HALF_W-1:0] shadow;

    st_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cfg_q (cfg_q)
    );

    st_tick_gen u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_slow   (tick_slow),
        .tick_fast   (tick_fast),
        .dbg_halt    (dbg_halt),
        .run         (cfg_q.run),
        .halt_freeze (cfg_q.halt_freeze),
        .src_fast    (cfg_q.src_fast),
        .div         (cfg_q.div),
        .active      (active),
        .step        (step)
    );

    st_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .down  (cfg_q.down),
        .cnt   (cnt)
    );

    st_readback #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .addr   (addr),
        .cfg    (cfg_q),
        .cnt    (cnt),
        .rdata  (rdata),
        .shadow (shadow)
    );
endmodule

// File: rtl/st_timer_chk.sv
module st_timer_chk
    import st_pkg::*;
#(
    parameter int CNT_W = 32,
    localparam int HALF_W = CNT_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_slow,
    input logic              tick_fast,
    input logic              dbg_halt,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input st_cfg_t           cfg,
    input logic              active,
    input logic              step,
    input logic [CNT_W-1:0]  cnt,
    input logic [HALF_W-1:0] shadow
);
    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        step && !cfg.down |=> cnt == $past(cnt) + CNT_W'(1));

    a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        step && cfg.down |=> cnt == $past(cnt) - CNT_W'(1));

    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));

    a_r5_step_on_selected_tick: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cfg.src_fast ? tick_fast : tick_slow));

    a_r6_step_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> active);

    a_r6_active_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg.src_fast ? tick_fast : tick_slow) |=> $stable(active));

    a_r7_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.run |=> $stable({cfg.down, cfg.src_fast, cfg.div}));

    a_r8_freeze_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.halt_freeze && dbg_halt |-> !step);

    a_r9_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_LO |=> shadow == $past(cnt[CNT_W-1:HALF_W]));

    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == ADDR_LO) |=> $stable(shadow));
endmodule

bind slow_tick_timer st_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .dbg_halt  (dbg_halt),
    .rd_en     (rd_en),
    .addr      (addr),
    .cfg       (cfg_q),
    .active    (active),
    .step      (step),
    .cnt       (cnt),
    .shadow    (shadow)
);

// File: tb/slow_tick_timer_tb.sv
`timescale 1ns/1ps
module slow_tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] exp_cnt = 32'd0;

    slow_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .dbg_halt(dbg_halt), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick(input bit fast);
        @(negedge clk);
        if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
        @(negedge clk); tick_fast = 1'b0; tick_slow = 1'b0;
    endtask

    task automatic ticks(input bit fast, input int n);
        for (int i = 0; i < n; i++) tick(fast);
    endtask

    task automatic rd_cnt(output logic [31:0] v);
        logic [31:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = {hi[15:0], lo[15:0]};
    endtask

    task automatic check_cnt(input string tag);
        logic [31:0] v;
        rd_cnt(v);
        check(tag, v, exp_cnt);
    endtask

    function automatic logic [31:0] steps_for(input int k, input int n);
        return 32'(k >> n);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 cfg reset", v, 32'h0000_0004);
        check_cnt("R1 count reset");

        // R3 wrap down then up; R9 shadow across the wrap
        wr(8'h03); ticks(0, 2); wr(8'h02); ticks(0, 3);
        exp_cnt = 32'hFFFF_FFFE;
        rd(2'd1, v); check("R3 low after down wrap", v, 32'h0000_FFFE);
        rd(2'd2, v); check("R9 high shadow", v, 32'h0000_FFFF);
        wr(8'h01); ticks(0, 2); wr(8'h00); ticks(0, 3);
        exp_cnt = 32'h0;
        rd(2'd2, v); check("R9 high held without low read", v, 32'h0000_FFFF);
        rd(2'd1, v); check("R3 low after up wrap", v, 32'h0);
        rd(2'd2, v); check("R9 high after new low read", v, 32'h0);

        // R6 latency, R7 lock
        wr(8'h01);
        tick(0); check_cnt("R6 first tick after enable");
        tick(0); check_cnt("R6 second tick after enable");
        wr(8'h5B);
        rd(2'd0, v); check("R7 locked fields", v, 32'h0000_0001);
        tick(0); exp_cnt += 1; check_cnt("R6 third tick counts, R2 up");
        wr(8'h00);
        tick(0); exp_cnt += 1; check_cnt("R6 first tick after disable");
        tick(0); exp_cnt += 1; check_cnt("R6 second tick after disable");
        tick(0); check_cnt("R6 third tick after disable idle");
        wr(8'h5A);
        rd(2'd0, v); check("R7 fields writable when stopped", v, 32'h0000_005A);

        // R8 freeze with divider 2
        wr(8'h15); ticks(0, 3);
        dbg_halt = 1'b1; ticks(0, 3);
        check_cnt("R8 frozen during halt");
        dbg_halt = 1'b0; tick(0); exp_cnt += 1;
        check_cnt("R8 resumes with prescaler held, R4");
        wr(8'h11); dbg_halt = 1'b1; ticks(0, 2); exp_cnt += 1;
        check_cnt("R8 halt ignored when freeze bit clear");
        dbg_halt = 1'b0;
        wr(8'h10); ticks(0, 3); exp_cnt += 1;
        check_cnt("R4 trailing ticks after disable");

        // R5 source select
        wr(8'h09); ticks(0, 5); check_cnt("R5 slow ignored while fast selected");
        ticks(1, 2); ticks(0, 3); check_cnt("R5 still latent");
        tick(1); exp_cnt += 1; check_cnt("R5 fast tick counts");
        wr(8'h08); ticks(1, 3); exp_cnt += 2; check_cnt("R5 fast trailing");

        // random runs: R2 R3 R4 R5
        for (int it = 0; it < 30; it++) begin
            int n, k;
            bit dn, fast, frz;
            logic [7:0] c;
            n = int'($urandom_range(3, 0));
            k = int'($urandom_range(20, 2));
            dn = 1'($urandom_range(1, 0));
            fast = 1'($urandom_range(1, 0));
            frz = 1'($urandom_range(1, 0));
            c = {4'(n), fast, frz, dn, 1'b1};
            wr(c);
            for (int t = 0; t < k; t++) begin
                if (!frz) dbg_halt = 1'($urandom_range(1, 0));
                if ($urandom_range(2, 0) == 0) tick(!fast);
                tick(fast);
            end
            dbg_halt = 1'b0;
            wr(c & 8'hFE);
            ticks(fast, 3);
            if (dn) exp_cnt -= steps_for(k, n); else exp_cnt += steps_for(k, n);
            rd(2'd0, v); check("R7 cfg readback random", v, {24'h0, c & 8'hFE});
            check_cnt(dn ? "R3 R4 random down run" : "R2 R4 random up run");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule